// File: doc/BRIEF.md
# Banked Scratchpad Memory Access Unit

This block is the internal data-memory access unit of a small 8-bit microcontroller. It contains a 256-byte scratchpad RAM. Each request carries an access kind that decides where the 8-bit address points: a direct byte, a byte through a register pointer, a single bit, or a working register of the active bank. The instruction sequencer issues one request per cycle on a valid strobe. Read results come back registered, one cycle later.

The upper address half, 80h to FFh, leads to two separate places. A direct byte access there goes out on a special-function-register port. A pointer access there reaches the upper 128 RAM bytes. Bit numbers 00h to 7Fh cover the 16 RAM bytes from 20h to 2Fh. Bit numbers 80h to FFh cover the special-function registers whose address is a multiple of eight. A bit write is carried out as a read of the target byte, then a write of that byte with one bit changed, in the following cycle. The working-register bank comes from the two bank-select bits of the status word. The status word itself lives outside the block and drives the `bank_sel` input.

Top module: `scratch_access_unit`

## Requirements
- R1: A direct access (kind 0) with address 00h–7Fh reads or writes that RAM byte. For a read, `rd_valid` is high in the cycle after the request, and `rd_data` then holds the byte.
- R2: A direct access (kind 0) with address 80h–FFh drives `sfr_req` in the same cycle, with `sfr_addr` equal to the address, `sfr_we` equal to `req_we` and `sfr_wdata` equal to `req_wdata`. A read returns `sfr_rdata` sampled in the request cycle. No RAM byte changes.
- R3: A pointer access (kind 1) uses as its target address the content of R0 (`req_addr[0]`=0) or R1 (`req_addr[0]`=1) of the active bank. It reaches every RAM byte 00h–FFh and never asserts `sfr_req`.
- R4: A bit access (kind 2) with bit number n below 80h targets RAM byte 20h + n/8, bit n mod 8. Bit position 0 is the LSB.
- R5: A bit access with bit number n of 80h or above targets the special-function register at n with its low three bits cleared, through the SFR port.
- R6: A working-register access (kind 3) targets RAM byte bank_sel×8 + `req_addr[2:0]`. Bank 0 is at 00h–07h and bank 3 is at 18h–1Fh.
- R7: A bit write reads the target in the request cycle and writes it in the next cycle, with only the selected bit set to `req_wbit`. During that write cycle `req_ready` is low, and any request presented is ignored.
- R8: A bit read returns the selected bit on `rd_bit` and the whole target byte on `rd_data`, one cycle after the request.
- R9: After reset `req_ready` is high, and `rd_valid` and `sfr_req` are low. RAM contents are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 direct, 1 pointer, 2 bit, 3 working register |
| req_we | input | 1 | Write when high |
| req_addr | input | 8 | Address, bit number, pointer select or register number |
| req_wdata | input | 8 | Byte write data |
| req_wbit | input | 1 | Bit write value |
| bank_sel | input | 2 | Bank-select bits of the status word |
| req_ready | output | 1 | Low while a bit write completes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read byte |
| rd_bit | output | 1 | Selected bit for bit reads |
| sfr_req | output | 1 | SFR port strobe |
| sfr_we | output | 1 | SFR port write flag |
| sfr_addr | output | 8 | SFR port address |
| sfr_wdata | output | 8 | SFR port write data |
| sfr_rdata | input | 8 | SFR port read data, valid in the strobe cycle |

## Verification
Several rules are checked on every cycle by properties. A direct upper-half access leaves the addressed RAM byte unchanged. A pointer access never strobes the SFR port. The write phase of a bit write alters at most one RAM bit and lasts a single cycle. Address translation cannot be shown that way: the bit-number mapping, the bank arithmetic and the pointer indirection are shown only by the bench's scenarios. They write through one mode and read back through another, including the same upper address written directly and through a pointer. The rule that requests are ignored during the write phase is also shown only by the bench.

// File: rtl/scratch_access_unit.sv
module scratch_access_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       req_we,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       req_wbit,
  input  logic [1:0] bank_sel,
  output logic       req_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_bit,
  output logic       sfr_req,
  output logic       sfr_we,
  output logic [7:0] sfr_addr,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata
);
  localparam logic [1:0] K_DIR = 2'd0, K_PTR = 2'd1, K_BIT = 2'd2, K_REG = 2'd3;

  logic [7:0] ram [256];
  logic       wb_pend, wb_sfr;
  logic [7:0] wb_addr, wb_byte;
  logic [7:0] tgt;

  wire       accept  = req_valid && !wb_pend;
  wire [7:0] ptr     = ram[{3'b000, bank_sel, 2'b00, req_addr[0]}];

  always_comb begin
    case (req_kind)
      K_DIR:   tgt = req_addr;
      K_PTR:   tgt = ptr;
      K_BIT:   tgt = req_addr[7] ? {req_addr[7:3], 3'b000} : {4'b0010, req_addr[6:3]};
      default: tgt = {3'b000, bank_sel, req_addr[2:0]};
    endcase
  end

  wire       tgt_sfr = req_addr[7] && (req_kind == K_DIR || req_kind == K_BIT);
  wire [7:0] cur     = tgt_sfr ? sfr_rdata : ram[tgt];
  wire [7:0] mask    = 8'd1 << req_addr[2:0];
  wire [7:0] merged  = req_wbit ? (cur | mask) : (cur & ~mask);
  wire       byte_wr = accept && req_we && req_kind != K_BIT;
  wire       bit_wr  = accept && req_we && req_kind == K_BIT;

  assign req_ready = !wb_pend;
  assign sfr_req   = wb_pend ? wb_sfr  : accept && tgt_sfr;
  assign sfr_we    = wb_pend ? wb_sfr  : byte_wr && tgt_sfr;
  assign sfr_addr  = wb_pend ? wb_addr : tgt;
  assign sfr_wdata = wb_pend ? wb_byte : req_wdata;

  always_ff @(posedge clk) begin
    if (wb_pend && !wb_sfr)
      ram[wb_addr] <= wb_byte;
    else if (byte_wr && !tgt_sfr)
      ram[tgt] <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_pend  <= 1'b0;
      wb_sfr   <= 1'b0;
      wb_addr  <= '0;
      wb_byte  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_bit   <= 1'b0;
    end else begin
      wb_pend  <= bit_wr;
      rd_valid <= accept && !req_we;
      if (bit_wr) begin
        wb_sfr  <= tgt_sfr;
        wb_addr <= tgt;
        wb_byte <= merged;
      end
      if (accept && !req_we) begin
        rd_data <= cur;
        rd_bit  <= cur[req_addr[2:0]];
      end
    end
  end

  p_upper_direct_keeps_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_kind == K_DIR && req_addr[7] && req_we
      |=> ram[$past(req_addr)] == $past(ram[req_addr]));

  p_pointer_never_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_kind == K_PTR |-> !sfr_req);

  p_bit_write_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pend && !wb_sfr
      |=> $countones(ram[$past(wb_addr)] ^ $past(ram[wb_addr])) <= 1);

  p_write_phase_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pend |=> !wb_pend);

  p_sfr_write_has_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> sfr_req);

  p_read_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid) && !$past(req_we));
endmodule

// File: tb/scratch_access_unit_tb_top.sv
module scratch_access_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_wbit = 0;
  logic [1:0] req_kind = 0, bank_sel = 0;
  logic [7:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rd_valid, rd_bit, sfr_req, sfr_we;
  logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;
  logic [7:0] sfr_mem [256];
  logic [7:0] m [256];
  logic [7:0] es [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scratch_access_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wbit(req_wbit), .bank_sel(bank_sel), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit),
    .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata));

  assign sfr_rdata = sfr_mem[sfr_addr];
  always @(posedge clk) if (sfr_req && sfr_we) sfr_mem[sfr_addr] <= sfr_wdata;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_sfr(logic [1:0] k, logic [7:0] a);
    return a[7] && (k == 2'd0 || k == 2'd2);
  endfunction

  function automatic logic [7:0] eaddr(logic [1:0] k, logic [7:0] a, logic [1:0] b);
    case (k)
      2'd0: return a;
      2'd1: return m[b * 8 + a[0]];
      2'd2: return a[7] ? (a & 8'hF8) : 8'h20 + a / 8;
      default: return b * 8 + a[2:0];
    endcase
  endfunction

  function automatic string tag(logic [1:0] k, logic [7:0] a);
    case (k)
      2'd0: return a[7] ? "R2" : "R1";
      2'd1: return "R3";
      2'd2: return a[7] ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic op(logic [1:0] k, logic w, logic [7:0] a, logic [7:0] d, logic wb);
    logic [7:0] t = eaddr(k, a, bank_sel);
    bit s = is_sfr(k, a);
    logic [7:0] old = s ? es[t] : m[t];
    logic [7:0] nv;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_we = w; req_addr = a; req_wdata = d; req_wbit = wb;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!w) begin
      chk({tag(k, a), " rd_valid"}, rd_valid, 1);
      chk({tag(k, a), " rd_data"}, rd_data, old);
      if (k == 2'd2) chk("R8 rd_bit", rd_bit, old[a[2:0]]);
    end else begin
      if (k == 2'd2) begin
        chk("R7 ready low", req_ready, 0);
        @(posedge clk);
        @(negedge clk);
        nv = old; nv[a[2:0]] = wb;
      end else nv = d;
      if (s) es[t] = nv; else m[t] = nv;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin sfr_mem[i] = i ^ 8'h5A; es[i] = i ^ 8'h5A; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 ready", req_ready, 1);
    chk("R9 rd_valid", rd_valid, 0);
    chk("R9 sfr_req", sfr_req, 0);
    rst_n = 1;

    for (int i = 0; i < 128; i++) op(2'd0, 1, i[7:0], 8'(i * 7 + 3), 0);
    for (int i = 128; i < 256; i++) begin
      op(2'd3, 1, 8'd0, i[7:0], 0);
      op(2'd1, 1, 8'd0, 8'(i * 13), 0);
    end
    op(2'd1, 0, 8'd0, 0, 0);

    // R2/R3: same upper address through direct and pointer modes
    op(2'd0, 1, 8'h90, 8'hAA, 0);
    op(2'd3, 1, 8'd1, 8'h90, 0);
    op(2'd1, 1, 8'd1, 8'h55, 0);
    op(2'd0, 0, 8'h90, 0, 0);
    chk("R2 sfr byte", rd_data, 8'hAA);
    op(2'd1, 0, 8'd1, 0, 0);
    chk("R3 ram byte", rd_data, 8'h55);

    // R4 bit ends of the RAM bit area
    op(2'd2, 1, 8'h00, 0, 1);
    op(2'd0, 0, 8'h20, 0, 0);
    chk("R4 bit0 lsb", rd_data[0], 1);
    op(2'd2, 1, 8'h7F, 0, 0);
    op(2'd0, 0, 8'h2F, 0, 0);
    chk("R4 bit7F msb", rd_data[7], 0);
    op(2'd2, 0, 8'h7F, 0, 0);

    // R5 SFR bit
    op(2'd2, 1, 8'hD3, 0, 1);
    op(2'd0, 0, 8'hD0, 0, 0);
    chk("R5 sfr bit", rd_data[3], 1);

    // R6 bank arithmetic
    bank_sel = 2'd2;
    op(2'd3, 1, 8'd5, 8'hC3, 0);
    op(2'd0, 0, 8'h15, 0, 0);
    chk("R6 bank2 r5", rd_data, 8'hC3);
    bank_sel = 2'd3;
    op(2'd3, 1, 8'd7, 8'h3C, 0);
    op(2'd0, 0, 8'h1F, 0, 0);
    chk("R6 bank3 r7", rd_data, 8'h3C);

    // R7 request during write phase is ignored
    @(negedge clk);
    req_valid = 1; req_kind = 2'd2; req_we = 1; req_addr = 8'h08; req_wbit = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 ready low", req_ready, 0);
    req_kind = 2'd0; req_addr = 8'h40; req_wdata = 8'hEE;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R7 ready back", req_ready, 1);
    m[8'h21][0] = 1'b1;
    op(2'd0, 0, 8'h40, 0, 0);
    op(2'd0, 0, 8'h21, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] k = 2'($urandom);
      bank_sel = 2'($urandom);
      op(k, 1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule